// File: doc/BRIEF.md
# SPI Block-Transfer Engine with Command-Byte Trigger

This block moves bytes between a 1 KiB transfer buffer and an SD card over SPI, with no CPU work once a transfer has begun. The host CPU fills the buffer through plain bus writes. It then writes a single command byte to a trigger address just below the buffer. That byte carries a length, counted in 8-byte units, and a direction. Two reserved values of the byte instead select the fast SCK rate, or stop the clock and return the block to its power-up slow rate.

During a transfer the engine walks the buffer from its first byte upward. Each byte takes four states. FETCH reads the buffer. LATCH loads the shift register, with 0xFF in receive direction. SHIFT clocks out eight bits in SPI mode 0, MSB first. STORE writes the received byte back in receive direction and advances the index. The named transitions are:

- IDLE→FETCH on an accepted start.
- FETCH→LATCH and LATCH→SHIFT unconditionally.
- SHIFT→STORE on the falling SCK edge that follows the eighth rising edge.
- STORE→FETCH while bytes remain, and STORE→IDLE on the last byte.
- ANY→IDLE on the stop code.

The buffer has one port. The engine has priority on it; the host uses it in every other cycle. A busy output is high for the whole transfer, and a done output pulses once when a transfer completes.

Top module: `sd_spi_dma`

## Requirements
- R1: A host write to an address whose bits 15..10 equal those of 0x9800 stores the data at buffer offset addr[9:0]. A host read there returns that byte on bus_rdata in the following cycle.
- R2: A host write to 0x97FF while idle, with L = data[7:1] in 1..126 and data not 0xFE or 0xFF, starts a transfer of 8·L bytes from buffer offset 0. busy is 1 from the next cycle.
- R3: In transmit direction (data[0] = 0), buffer bytes are sent MSB first. SCK rests low, MOSI changes only while SCK is low, and MISO has no effect.
- R4: In receive direction (data[0] = 1), MOSI stays 1 for the whole transfer. MISO is sampled at each SCK rise, and received byte k is written to buffer offset k.
- R5: Writing 0xFE to 0x97FF while idle starts no transfer and selects the fast half period FAST_HALF for later transfers.
- R6: Writing 0xFF to 0x97FF at any time ends any transfer at once, drives SCK low, gives no done pulse, and restores the slow half period SLOW_HALF.
- R7: After reset the block is idle and slow, with busy = 0, done = 0, SCK = 0 and MOSI = 1.
- R8: Trigger writes other than 0xFF are ignored while busy. Trigger values 0x00 and 0x01 (zero length) are ignored at all times.
- R9: Each byte takes exactly 16·H + 3 clock cycles, where H is the half period that was in force at the start.
- R10: done is 1 for exactly one cycle, the first idle cycle after the last byte's STORE.
- R11: A host buffer write presented in a cycle where the engine uses the port (FETCH, or STORE in receive direction) is dropped. Host buffer writes in all other cycles take effect, even while busy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Host address |
| bus_wdata | input | 8 | Host write data |
| bus_we | input | 1 | Host write strobe |
| bus_re | input | 1 | Host buffer read strobe |
| bus_rdata | output | 8 | Buffer read data, one cycle after the read |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| spi_sck | output | 1 | SPI clock, mode 0 |
| spi_mosi | output | 1 | SPI data to the card |
| spi_miso | input | 1 | SPI data from the card |

## Verification
Two functions can fall in the same cycle. The first is a host buffer write in the same cycle as the engine's write-back of a received byte. The bench places a host write to offset 3 exactly in the STORE cycle of byte 3 of a receive transfer. It then reads offset 3 back and expects the card's byte, not the host's. The second is a trigger write arriving while a transfer runs. The bench issues a new length during a slow transmit and a stop code in the middle of a receive. The first must leave the transfer length unchanged, and the second must abort on the following cycle.

// File: rtl/sd_spi_dma_pkg.sv
package sd_spi_dma_pkg;

    localparam int LEN_W   = 7;              // length field of the command byte
    localparam int UNIT_SH = 3;              // one length unit = 2**UNIT_SH bytes
    localparam int CNT_W   = LEN_W + UNIT_SH;

    localparam logic [7:0] CODE_FAST = 8'hFE;
    localparam logic [7:0] CODE_STOP = 8'hFF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_LATCH,
        ST_SHIFT,
        ST_STORE
    } eng_state_t;

    typedef struct packed {
        logic             start;
        logic             stop;
        logic             fast;
        logic             dir;
        logic [LEN_W-1:0] units;
    } cmd_t;

endpackage

// File: rtl/sdd_cmd_decode.sv
module sdd_cmd_decode
    import sd_spi_dma_pkg::*;
#(
    parameter logic [15:0] TRIG_ADDR = 16'h97FF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] bus_addr,
    input  logic [7:0]  bus_wdata,
    input  logic        bus_we,
    input  logic        busy,
    output cmd_t        cmd
);

    logic hit;
    logic reserved;

    always_comb begin
        hit       = bus_we && (bus_addr == TRIG_ADDR);
        // reserved codes are recognised before any length decode
        reserved  = (bus_wdata == CODE_FAST) || (bus_wdata == CODE_STOP);
        cmd.stop  = hit && (bus_wdata == CODE_STOP);
        cmd.fast  = hit && !busy && (bus_wdata == CODE_FAST);
        cmd.start = hit && !busy && !reserved && (bus_wdata[7:1] != '0);
        cmd.dir   = bus_wdata[0];
        cmd.units = bus_wdata[7:1];
    end

    p_no_start_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !cmd.start);

    p_codes_not_transfer_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.fast || cmd.stop) |-> !cmd.start);

endmodule

// File: rtl/sdd_sck_timer.sv
module sdd_sck_timer #(
    parameter int SLOW_HALF = 125,
    parameter int FAST_HALF = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_fast,
    input  logic set_slow,
    input  logic run,
    output logic tick,
    output logic fast
);

    localparam int HALF_MAX = (SLOW_HALF > FAST_HALF) ? SLOW_HALF : FAST_HALF;
    localparam int CW       = $clog2(HALF_MAX + 1);
    localparam logic [CW-1:0] SLOW_LAST = CW'(SLOW_HALF - 1);
    localparam logic [CW-1:0] FAST_LAST = CW'(FAST_HALF - 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last;
    logic          fast_q;

    assign last = fast_q ? FAST_LAST : SLOW_LAST;
    assign tick = run && (cnt_q == last);
    assign fast = fast_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fast_q <= 1'b0;
        end else if (set_slow) begin
            fast_q <= 1'b0;
        end else if (set_fast) begin
            fast_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    p_tick_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q <= last));

    p_fast_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (set_fast && !set_slow) |=> fast_q);

    p_slow_restore_r6: assert property (@(posedge clk) disable iff (!rst_n)
        set_slow |=> !fast_q);

endmodule

// File: rtl/sdd_buffer.sv
module sdd_buffer #(
    parameter int          AW       = 10,
    parameter logic [15:0] BUF_BASE = 16'h9800
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [15:0]   host_addr,
    input  logic [7:0]    host_wdata,
    input  logic          host_we,
    input  logic          host_re,
    input  logic          eng_rd,
    input  logic          eng_wr,
    input  logic [AW-1:0] eng_addr,
    input  logic [7:0]    eng_wdata,
    output logic [7:0]    rdata
);

    localparam int DEPTH = 2 ** AW;

    logic [7:0]    mem [DEPTH];
    logic          in_range;
    logic          eng_sel;
    logic [AW-1:0] p_addr;
    logic [7:0]    p_wdata;
    logic          p_we;
    logic          p_re;

    // engine wins the single port; host uses every cycle left over
    always_comb begin
        in_range = (host_addr[15:AW] == BUF_BASE[15:AW]);
        eng_sel  = eng_rd || eng_wr;
        p_addr   = eng_sel ? eng_addr  : host_addr[AW-1:0];
        p_wdata  = eng_sel ? eng_wdata : host_wdata;
        p_we     = eng_sel ? eng_wr    : (host_we && in_range);
        p_re     = eng_sel ? eng_rd    : (host_re && in_range);
    end

    always_ff @(posedge clk) begin
        if (p_we) begin
            mem[p_addr] <= p_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= 8'h00;
        end else if (p_re) begin
            rdata <= mem[p_addr];
        end
    end

    p_single_engine_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(eng_rd && eng_wr));

    p_engine_write_lands_r11: assert property (@(posedge clk) disable iff (!rst_n)
        eng_wr |=> (mem[$past(eng_addr)] == $past(eng_wdata)));

endmodule

// File: rtl/sdd_engine.sv
module sdd_engine
    import sd_spi_dma_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_start,
    input  logic             cmd_stop,
    input  logic             cmd_dir,
    input  logic [LEN_W-1:0] cmd_units,
    input  logic             tick,
    input  logic [7:0]       mem_rdata,
    input  logic             miso,
    output logic             shift_run,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic [AW-1:0]    mem_addr,
    output logic [7:0]       mem_wdata,
    output logic             sck,
    output logic             mosi,
    output logic             busy,
    output logic             done
);

    eng_state_t       state, state_n;
    logic [AW-1:0]    idx_q;
    logic [CNT_W-1:0] remain_q;
    logic             dir_q;
    logic [7:0]       tx_q;
    logic [7:0]       rx_q;
    logic [2:0]       bit_q;
    logic             sck_q;
    logic             done_q;
    logic             last_bit;
    logic             last_byte;

    assign last_bit  = tick && sck_q && (bit_q == 3'd7);
    assign last_byte = (remain_q == CNT_W'(1));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_n;
        end
    end

    // next state
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:  if (cmd_start) state_n = ST_FETCH;
            ST_FETCH: state_n = ST_LATCH;
            ST_LATCH: state_n = ST_SHIFT;
            ST_SHIFT: if (last_bit) state_n = ST_STORE;
            ST_STORE: state_n = last_byte ? ST_IDLE : ST_FETCH;
            default:  state_n = ST_IDLE;
        endcase
        if (cmd_stop) begin
            state_n = ST_IDLE;
        end
    end

    // outputs
    always_comb begin
        busy      = (state != ST_IDLE);
        shift_run = (state == ST_SHIFT);
        mem_rd    = (state == ST_FETCH);
        mem_wr    = (state == ST_STORE) && dir_q;
        mem_addr  = idx_q;
        mem_wdata = rx_q;
        mosi      = (state == ST_SHIFT) ? tx_q[7] : 1'b1;
        sck       = sck_q;
        done      = done_q;
    end

    // datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q    <= '0;
            remain_q <= '0;
            dir_q    <= 1'b0;
            tx_q     <= 8'hFF;
            rx_q     <= 8'h00;
            bit_q    <= 3'd0;
            sck_q    <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= (state == ST_STORE) && last_byte && !cmd_stop;
            if (cmd_stop) begin
                sck_q <= 1'b0;
            end else begin
                unique case (state)
                    ST_IDLE: begin
                        if (cmd_start) begin
                            idx_q    <= '0;
                            remain_q <= {cmd_units, {UNIT_SH{1'b0}}};
                            dir_q    <= cmd_dir;
                        end
                    end
                    ST_FETCH: ;
                    ST_LATCH: begin
                        tx_q  <= dir_q ? 8'hFF : mem_rdata;
                        bit_q <= 3'd0;
                        sck_q <= 1'b0;
                    end
                    ST_SHIFT: begin
                        if (tick) begin
                            if (!sck_q) begin
                                sck_q <= 1'b1;
                                rx_q  <= {rx_q[6:0], miso};
                            end else begin
                                sck_q <= 1'b0;
                                if (bit_q != 3'd7) begin
                                    tx_q  <= {tx_q[6:0], 1'b1};
                                    bit_q <= bit_q + 3'd1;
                                end
                            end
                        end
                    end
                    ST_STORE: begin
                        idx_q    <= idx_q + AW'(1);
                        remain_q <= remain_q - CNT_W'(1);
                    end
                    default: ;
                endcase
            end
        end
    end

    p_sck_rest_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_SHIFT) |-> !sck_q);

    p_mosi_moves_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT && $past(state) == ST_SHIFT && !$stable(mosi)) |-> !sck_q);

    p_rx_mosi_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT && dir_q) |-> mosi);

    p_start_offset_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && cmd_start && !cmd_stop) |=> (state == ST_FETCH && idx_q == '0));

    p_stop_aborts_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stop |=> (state == ST_IDLE && !sck_q && !done_q));

    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    p_done_after_store_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (state == ST_IDLE && $past(state) == ST_STORE));

endmodule

// File: rtl/sd_spi_dma.sv
module sd_spi_dma
    import sd_spi_dma_pkg::*;
#(
    parameter int          BUF_DEPTH = 1024,
    parameter logic [15:0] BUF_BASE  = 16'h9800,
    parameter logic [15:0] TRIG_ADDR = 16'h97FF,
    parameter int          SLOW_HALF = 125,
    parameter int          FAST_HALF = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] bus_addr,
    input  logic [7:0]  bus_wdata,
    input  logic        bus_we,
    input  logic        bus_re,
    output logic [7:0]  bus_rdata,
    output logic        busy,
    output logic        done,
    output logic        spi_sck,
    output logic        spi_mosi,
    input  logic        spi_miso
);

    localparam int AW = $clog2(BUF_DEPTH);

    cmd_t          cmd;
    logic          tick;
    logic          fast_mode;
    logic          shift_run;
    logic          mem_rd;
    logic          mem_wr;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata;
    logic [7:0]    mem_rdata;

    sdd_cmd_decode #(.TRIG_ADDR(TRIG_ADDR)) u_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .busy      (busy),
        .cmd       (cmd)
    );

    sdd_sck_timer #(.SLOW_HALF(SLOW_HALF), .FAST_HALF(FAST_HALF)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_fast (cmd.fast),
        .set_slow (cmd.stop),
        .run      (shift_run),
        .tick     (tick),
        .fast     (fast_mode)
    );

    sdd_buffer #(.AW(AW), .BUF_BASE(BUF_BASE)) u_buffer (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_addr  (bus_addr),
        .host_wdata (bus_wdata),
        .host_we    (bus_we),
        .host_re    (bus_re),
        .eng_rd     (mem_rd),
        .eng_wr     (mem_wr),
        .eng_addr   (mem_addr),
        .eng_wdata  (mem_wdata),
        .rdata      (mem_rdata)
    );

    sdd_engine #(.AW(AW)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_start (cmd.start),
        .cmd_stop  (cmd.stop),
        .cmd_dir   (cmd.dir),
        .cmd_units (cmd.units),
        .tick      (tick),
        .mem_rdata (mem_rdata),
        .miso      (spi_miso),
        .shift_run (shift_run),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .sck       (spi_sck),
        .mosi      (spi_mosi),
        .busy      (busy),
        .done      (done)
    );

    assign bus_rdata = mem_rdata;

    p_fast_only_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !cmd.stop) |=> $stable(fast_mode));

endmodule

// File: tb/tb_sd_spi_dma.sv
`timescale 1ns/1ps
module tb_sd_spi_dma;

    localparam int SH = 3;
    localparam int FH = 1;
    localparam logic [15:0] TRIG = 16'h97FF;
    localparam logic [15:0] BASE = 16'h9800;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic        spi_miso = 1'b0;
    wire  [7:0]  bus_rdata;
    wire         busy, done, spi_sck, spi_mosi;

    sd_spi_dma #(.SLOW_HALF(SH), .FAST_HALF(FH)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata), .busy(busy),
        .done(done), .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit run_checks = 0;

    // reference model state
    bit   m_busy = 0, m_done = 0, m_fast = 0, m_dir = 0;
    int   m_off = 0, m_len = 0, m_h = SH;
    logic [7:0] mmem [1024];

    initial for (int i = 0; i < 1024; i++) mmem[i] = 8'h00;

    function automatic logic [7:0] pat(input int k);
        return 8'((k * 37 + 5) & 255);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // model advance on each rising edge
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_fast = 0;
        end else begin
            bit trig, hostw, drop;
            int per, k, o;
            trig  = bus_we && (bus_addr == TRIG);
            hostw = bus_we && (bus_addr[15:10] == BASE[15:10]);
            m_done = 0;
            if (trig && bus_wdata == 8'hFF) begin
                m_busy = 0; m_fast = 0;
            end else if (m_busy) begin
                per  = 16 * m_h + 3;
                k    = m_off / per;
                o    = m_off % per;
                drop = (o == 0) || (m_dir && o == per - 1);
                if (hostw && !drop) mmem[bus_addr[9:0]] = bus_wdata;
                if (m_dir && o == per - 1) mmem[k] = pat(k);
                if (m_off == m_len - 1) begin
                    m_busy = 0; m_done = 1;
                end else begin
                    m_off++;
                end
            end else begin
                if (hostw) mmem[bus_addr[9:0]] = bus_wdata;
                if (trig) begin
                    if (bus_wdata == 8'hFE) begin
                        m_fast = 1;
                    end else if (bus_wdata[7:1] != 7'd0) begin
                        m_busy = 1; m_off = 0; m_dir = bus_wdata[0];
                        m_h    = m_fast ? FH : SH;
                        m_len  = int'(bus_wdata[7:1]) * 8 * (16 * m_h + 3);
                    end
                end
            end
        end
    end

    // compare every cycle, away from the active edge; drive MISO as a card would
    always @(negedge clk) begin
        if (rst_n && run_checks) begin
            bit e_sck, e_mosi, e_miso;
            int per, k, o, s, h, b;
            logic [7:0] tb, rb;
            e_sck = 0; e_mosi = 1; e_miso = 0;
            if (m_busy) begin
                per = 16 * m_h + 3;
                k   = m_off / per;
                o   = m_off % per;
                if (o >= 2 && o < 2 + 16 * m_h) begin
                    s = o - 2; h = s / m_h; b = h / 2;
                    tb = mmem[k]; rb = pat(k);
                    e_sck  = h[0];
                    e_mosi = m_dir ? 1'b1 : tb[7 - b];
                    e_miso = rb[7 - b];
                end
            end
            chk(busy == m_busy, "R2", "busy per cycle", busy, m_busy);
            chk(done == m_done, "R10", "done per cycle", done, m_done);
            chk(spi_sck == e_sck, "R9", "sck per cycle", spi_sck, e_sck);
            chk(spi_mosi == e_mosi, m_dir ? "R4" : "R3", "mosi per cycle", spi_mosi, e_mosi);
            spi_miso = e_miso;
        end
    end

    // all tasks enter and leave at a falling edge
    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, input logic [7:0] exp, input string req);
        bus_addr = a; bus_re = 1'b1;
        @(negedge clk);
        bus_re = 1'b0;
        chk(bus_rdata == exp, req, "buffer readback", bus_rdata, exp);
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    always @(posedge clk) begin
        if (cyc > 60000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int t0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R7: reset state
        chk(busy == 0, "R7", "busy after reset", busy, 0);
        chk(done == 0, "R7", "done after reset", done, 0);
        chk(spi_sck == 0, "R7", "sck after reset", spi_sck, 0);
        chk(spi_mosi == 1, "R7", "mosi after reset", spi_mosi, 1);
        run_checks = 1;

        // R1: fill and read back
        for (int i = 0; i < 16; i++) wr(BASE + 16'(i), 8'((i * 29 + 17) & 255));
        rd(BASE + 16'd0, 8'd17, "R1");
        rd(BASE + 16'd7, 8'((7 * 29 + 17) & 255), "R1");
        rd(BASE + 16'd15, 8'((15 * 29 + 17) & 255), "R1");

        // R3, R9: slow transmit of 8 bytes; R8: new length while busy ignored
        wr(TRIG, 8'h02);
        t0 = cyc;
        chk(busy == 1, "R2", "busy after trigger", busy, 1);
        repeat (9) @(negedge clk);
        wr(TRIG, 8'h04);
        wait_idle();
        chk(cyc - t0 == 8 * 51, "R9", "slow transfer cycles (R8 length kept)", cyc - t0, 8 * 51);
        chk(done == 1, "R10", "done at end", done, 1);
        @(negedge clk);
        chk(done == 0, "R10", "done one cycle", done, 0);

        // R5: fast code starts nothing, speeds up next transfer
        wr(TRIG, 8'hFE);
        chk(busy == 0, "R5", "fast code no transfer", busy, 0);
        wr(TRIG, 8'h02);
        t0 = cyc;
        wait_idle();
        chk(cyc - t0 == 8 * 19, "R5", "fast transfer cycles", cyc - t0, 8 * 19);

        // R4, R11: receive 16 bytes; collide host write with STORE of byte 3
        wr(TRIG, 8'h05);
        t0 = cyc;
        repeat (4 * 19 - 1) @(negedge clk);
        wr(BASE + 16'd3, 8'h5A);
        repeat (5) @(negedge clk);
        wr(BASE + 16'd100, 8'h33);
        wait_idle();
        chk(cyc - t0 == 16 * 19, "R9", "receive transfer cycles", cyc - t0, 16 * 19);
        for (int k = 0; k < 16; k++) rd(BASE + 16'(k), pat(k), "R4");
        rd(BASE + 16'd3, pat(3), "R11");
        rd(BASE + 16'd100, 8'h33, "R11");

        // R8: zero-length codes
        wr(TRIG, 8'h00);
        chk(busy == 0, "R8", "length 0 dir 0 ignored", busy, 0);
        wr(TRIG, 8'h01);
        chk(busy == 0, "R8", "length 0 dir 1 ignored", busy, 0);

        // R6: stop mid-transfer, slow rate restored
        wr(TRIG, 8'h03);
        repeat (30) @(negedge clk);
        wr(TRIG, 8'hFF);
        chk(busy == 0, "R6", "busy after stop", busy, 0);
        chk(spi_sck == 0, "R6", "sck after stop", spi_sck, 0);
        chk(done == 0, "R6", "no done after stop", done, 0);
        wr(TRIG, 8'h02);
        t0 = cyc;
        wait_idle();
        chk(cyc - t0 == 8 * 51, "R6", "slow rate after stop", cyc - t0, 8 * 51);
        repeat (3) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule